// File: doc/BRIEF.md
# Ping-Pong Packed Frame Store Controller

This controller runs two single-port memory banks as an alternating frame store. A camera delivers pixels in raster order and they are written into one bank. At the same time a display side pulls pixels in raster order out of the other bank. When the camera finishes a frame and the display has read its whole frame, the two banks exchange roles.

To cut memory traffic, pixels are packed into 32-bit words. In colour mode a word holds two 16-bit pixels. In grey mode it holds four 8-bit pixels. A packing register on the write side gathers pixels and issues one bank write per word. On the read side, one fetch supplies a word, and its pixels are then handed out one per display request.

If the camera ends a frame before the display has finished reading the previous one, the exchange waits. A sticky overrun flag is raised, and camera pixels are discarded until the display catches up.

Top module: `pingpong_frame_store`

The role-exchange state machine has two states:
- `SW_RUN`: normal operation.
- `SW_WAIT`: an exchange is pending.
- Transitions: `SW_RUN -> SW_RUN` on an end of frame while the reader is idle (immediate exchange). `SW_RUN -> SW_WAIT` on an end of frame while the reader is busy (deferral). `SW_WAIT -> SW_RUN` once the reader becomes idle (late exchange).

The reader state machine has three states:
- `RD_IDLE`: no frame to read.
- `RD_FETCH`: the next request fetches a word.
- `RD_DRAIN`: the next request is served from the held word.
- Transitions: `RD_IDLE -> RD_FETCH` on an exchange. `RD_FETCH -> RD_DRAIN` on a request. `RD_DRAIN -> RD_FETCH` when the request takes the last pixel of a word. `RD_DRAIN -> RD_IDLE` when the request takes the last pixel of the frame.

## Requirements
- R1: After reset `wr_bank` is 0. Camera writes go only to the bank numbered `wr_bank`, and display fetches go only to the other bank.
- R2: A camera pixel accepted with `cam_eof` high ends the write frame. If the reader is idle, `wr_bank` toggles on that same clock edge, and the next frame is written starting at word address 0.
- R3: In colour mode (`cfg_grey`=0), the earlier pixel of each pair is stored in word bits 15:0 and the later one in bits 31:16.
- R4: In grey mode (`cfg_grey`=1), only `cam_pix[7:0]` is stored, four pixels per word. The earliest pixel goes in bits 7:0, then 15:8, then 23:16, then 31:24.
- R5: An end-of-frame pixel forces the write of a partly filled word. Its unused pixel slots are zero.
- R6: `cfg_grey` is sampled only while the writer sits at the start of a frame, so changing it mid-frame has no effect on that frame. The reader unpacks each frame in the mode it was written in. A grey pixel is output zero-extended to 16 bits.
- R7: Each accepted `disp_req` yields `disp_vld` with the next pixel in raster order exactly one cycle later. A frame is read with exactly one bank fetch per word.
- R8: When no frame is waiting to be read, `disp_req` is ignored: no `disp_vld` and no bank access.
- R9: An end of frame while the reader is busy sets `overrun`, which stays set until reset. In that case `wr_bank` holds, camera pixels are discarded, and the exchange happens once the reader has delivered its last pixel.
- R10: No bank is both written and read in the same cycle, and at most one bank is written per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_grey | input | 1 | Packing mode: 1 = four 8-bit grey pixels per word, 0 = two 16-bit pixels |
| cam_pix | input | 16 | Camera pixel |
| cam_valid | input | 1 | Camera pixel valid |
| cam_eof | input | 1 | Marks the last pixel of a camera frame |
| disp_req | input | 1 | Display request for one pixel |
| disp_pix | output | 16 | Pixel returned to the display |
| disp_vld | output | 1 | `disp_pix` valid |
| wr_bank | output | 1 | Bank currently written by the camera |
| overrun | output | 1 | Sticky deferred-exchange flag |
| b0_en | output | 1 | Bank 0 access enable |
| b0_we | output | 1 | Bank 0 write enable |
| b0_addr | output | ADDR_W | Bank 0 word address |
| b0_wdata | output | 32 | Bank 0 write word |
| b0_rdata | input | 32 | Bank 0 read word, one cycle after the access |
| b1_en | output | 1 | Bank 1 access enable |
| b1_we | output | 1 | Bank 1 write enable |
| b1_addr | output | ADDR_W | Bank 1 word address |
| b1_wdata | output | 32 | Bank 1 write word |
| b1_rdata | input | 32 | Bank 1 read word, one cycle after the access |

## Verification
The assertions check properties that must hold on every cycle:
- no bank is read while it is the writing bank;
- two banks are never written together;
- every `disp_vld` follows a request one cycle earlier;
- `overrun` never clears once set.

Other behaviour can only be shown by the bench's scenarios:
- the bit positions of packed pixels;
- zero-filled flushing at an early end of frame;
- mode capture at the start of a frame;
- raster order and fetch count on the read side;
- discarding of pixels while an exchange is deferred;
- the late exchange that follows the deferral.

// File: rtl/fbuf_pkg.sv
package fbuf_pkg;
    localparam int WORD_W = 32;
    localparam int PIX_W  = 16;
    localparam int GREY_W = 8;

    typedef enum logic [1:0] {RD_IDLE, RD_FETCH, RD_DRAIN} rd_state_t;
    typedef enum logic {SW_RUN, SW_WAIT} sw_state_t;

    // Extract pixel number 'slot' of a packed word, grey pixels zero-extended
    function automatic logic [PIX_W-1:0] unpack_pix(input logic [WORD_W-1:0] w,
                                                    input logic [1:0] slot,
                                                    input logic grey);
        logic [PIX_W-1:0] r;
        if (grey)
            r = {{(PIX_W-GREY_W){1'b0}}, w[{slot, 3'b000} +: GREY_W]};
        else
            r = slot[0] ? w[WORD_W-1:PIX_W] : w[PIX_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/fbuf_packer.sv
module fbuf_packer
    import fbuf_pkg::*;
#(
    parameter int ADDR_W = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_grey,
    input  logic [PIX_W-1:0]  pix,
    input  logic              valid,
    input  logic              eof,
    input  logic              drop,
    input  logic              swap,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [WORD_W-1:0] wr_data,
    output logic              wr_grey,
    output logic              frame_end
);
    logic [WORD_W-1:0] acc_q, merged;
    logic [1:0]        slot_q;
    logic [ADDR_W-1:0] addr_q;
    logic              grey_q;
    logic              take, last;

    always_comb begin
        merged = acc_q;
        if (grey_q)
            merged[{slot_q, 3'b000} +: GREY_W] = pix[GREY_W-1:0];
        else if (slot_q[0])
            merged[WORD_W-1:PIX_W] = pix;
        else
            merged[PIX_W-1:0] = pix;
    end

    assign take      = valid && !drop;
    assign last      = grey_q ? (slot_q == 2'd3) : (slot_q == 2'd1);
    assign wr_en     = take && (last || eof);
    assign wr_data   = merged;
    assign wr_addr   = addr_q;
    assign wr_grey   = grey_q;
    assign frame_end = take && eof;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            slot_q <= '0;
            addr_q <= '0;
            grey_q <= 1'b0;
        end else begin
            if (addr_q == '0 && slot_q == '0 && !drop)
                grey_q <= cfg_grey;
            if (swap) begin
                acc_q  <= '0;
                slot_q <= '0;
                addr_q <= '0;
            end else if (take) begin
                if (last || eof) begin
                    acc_q  <= '0;
                    slot_q <= '0;
                    addr_q <= addr_q + 1'b1;
                end else begin
                    acc_q  <= merged;
                    slot_q <= slot_q + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/fbuf_unpacker.sv
module fbuf_unpacker
    import fbuf_pkg::*;
#(
    parameter int FRAME_PIX = 442368,
    parameter int ADDR_W    = 18
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              start,
    input  logic              grey_in,
    input  logic [WORD_W-1:0] rdata,
    output logic              rd_en,
    output logic [ADDR_W-1:0] rd_addr,
    output logic [PIX_W-1:0]  pix,
    output logic              vld,
    output logic              idle
);
    localparam int WORDS_COL  = FRAME_PIX / 2;
    localparam int WORDS_GREY = FRAME_PIX / 4;

    rd_state_t         state, nxt;
    logic [ADDR_W-1:0] addr_q;
    logic [1:0]        slot_q, out_slot_q;
    logic              grey_q, out_grey_q, out_mem_q, out_vld_q;
    logic [WORD_W-1:0] hold_q;
    logic              accept, last_slot, frame_done;

    assign accept     = req && (state != RD_IDLE);
    assign last_slot  = grey_q ? (slot_q == 2'd3) : (slot_q == 2'd1);
    assign frame_done = addr_q == (grey_q ? ADDR_W'(WORDS_GREY) : ADDR_W'(WORDS_COL));

    always_comb begin
        nxt = state;
        unique case (state)
            RD_IDLE:  if (start) nxt = RD_FETCH;
            RD_FETCH: if (req) nxt = RD_DRAIN;
            RD_DRAIN: if (req && last_slot) nxt = frame_done ? RD_IDLE : RD_FETCH;
            default:  nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= nxt;
    end

    assign rd_en   = req && (state == RD_FETCH);
    assign rd_addr = addr_q;
    assign idle    = (state == RD_IDLE);
    assign vld     = out_vld_q;
    assign pix     = unpack_pix(out_mem_q ? rdata : hold_q, out_slot_q, out_grey_q);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q     <= '0;
            slot_q     <= '0;
            grey_q     <= 1'b0;
            out_vld_q  <= 1'b0;
            out_slot_q <= '0;
            out_grey_q <= 1'b0;
            out_mem_q  <= 1'b0;
            hold_q     <= '0;
        end else begin
            out_vld_q <= accept;
            if (accept) begin
                out_slot_q <= slot_q;
                out_grey_q <= grey_q;
                out_mem_q  <= (state == RD_FETCH);
                slot_q     <= last_slot ? 2'd0 : slot_q + 1'b1;
            end else begin
                out_mem_q  <= 1'b0;
            end
            if (out_mem_q) hold_q <= rdata;
            if (rd_en) addr_q <= addr_q + 1'b1;
            if (start && state == RD_IDLE) begin
                addr_q <= '0;
                slot_q <= '0;
                grey_q <= grey_in;
            end
        end
    end
endmodule

// File: rtl/fbuf_swap_ctrl.sv
module fbuf_swap_ctrl
    import fbuf_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic frame_end,
    input  logic rd_idle,
    output logic swap,
    output logic drop,
    output logic wr_sel,
    output logic overrun
);
    sw_state_t state, nxt;
    logic      defer;

    always_comb begin
        nxt   = state;
        swap  = 1'b0;
        defer = 1'b0;
        unique case (state)
            SW_RUN: begin
                if (frame_end) begin
                    if (rd_idle) begin
                        swap = 1'b1;
                    end else begin
                        defer = 1'b1;
                        nxt   = SW_WAIT;
                    end
                end
            end
            SW_WAIT: begin
                if (rd_idle) begin
                    swap = 1'b1;
                    nxt  = SW_RUN;
                end
            end
            default: nxt = SW_RUN;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= SW_RUN;
        else        state <= nxt;
    end

    assign drop = (state == SW_WAIT);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_sel  <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (swap)  wr_sel  <= ~wr_sel;
            if (defer) overrun <= 1'b1;
        end
    end
endmodule

// File: rtl/pingpong_frame_store.sv
module pingpong_frame_store
    import fbuf_pkg::*;
#(
    parameter int FRAME_PIX = 442368,
    parameter int ADDR_W    = $clog2(FRAME_PIX / 2 + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_grey,
    input  logic [15:0]       cam_pix,
    input  logic              cam_valid,
    input  logic              cam_eof,
    input  logic              disp_req,
    output logic [15:0]       disp_pix,
    output logic              disp_vld,
    output logic              wr_bank,
    output logic              overrun,
    output logic              b0_en,
    output logic              b0_we,
    output logic [ADDR_W-1:0] b0_addr,
    output logic [31:0]       b0_wdata,
    input  logic [31:0]       b0_rdata,
    output logic              b1_en,
    output logic              b1_we,
    output logic [ADDR_W-1:0] b1_addr,
    output logic [31:0]       b1_wdata,
    input  logic [31:0]       b1_rdata
);
    localparam int NBANK = 2;

    logic              wr_en, frame_end, wr_grey, swap, drop, wr_sel, rd_en, rd_idle;
    logic [ADDR_W-1:0] wr_addr, rd_addr;
    logic [WORD_W-1:0] wr_data, rd_word;
    logic [NBANK-1:0]  ben, bwe;
    logic [ADDR_W-1:0] badr [NBANK];

    fbuf_packer #(.ADDR_W(ADDR_W)) u_pack (
        .clk(clk), .rst_n(rst_n), .cfg_grey(cfg_grey), .pix(cam_pix),
        .valid(cam_valid), .eof(cam_eof), .drop(drop), .swap(swap),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_grey(wr_grey), .frame_end(frame_end)
    );

    fbuf_swap_ctrl u_swap (
        .clk(clk), .rst_n(rst_n), .frame_end(frame_end), .rd_idle(rd_idle),
        .swap(swap), .drop(drop), .wr_sel(wr_sel), .overrun(overrun)
    );

    fbuf_unpacker #(.FRAME_PIX(FRAME_PIX), .ADDR_W(ADDR_W)) u_unpack (
        .clk(clk), .rst_n(rst_n), .req(disp_req), .start(swap), .grey_in(wr_grey),
        .rdata(rd_word), .rd_en(rd_en), .rd_addr(rd_addr),
        .pix(disp_pix), .vld(disp_vld), .idle(rd_idle)
    );

    for (genvar b = 0; b < NBANK; b++) begin : g_bank
        assign ben[b]  = (wr_sel == 1'(b)) ? wr_en : rd_en;
        assign bwe[b]  = (wr_sel == 1'(b)) && wr_en;
        assign badr[b] = (wr_sel == 1'(b)) ? wr_addr : rd_addr;
    end

    assign rd_word  = wr_sel ? b0_rdata : b1_rdata;
    assign wr_bank  = wr_sel;
    assign b0_en    = ben[0];
    assign b0_we    = bwe[0];
    assign b0_addr  = badr[0];
    assign b0_wdata = wr_data;
    assign b1_en    = ben[1];
    assign b1_we    = bwe[1];
    assign b1_addr  = badr[1];
    assign b1_wdata = wr_data;
endmodule

// File: rtl/fbuf_checker.sv
module fbuf_checker (
    input logic clk,
    input logic rst_n,
    input logic disp_req,
    input logic disp_vld,
    input logic wr_bank,
    input logic overrun,
    input logic b0_en,
    input logic b0_we,
    input logic b1_en,
    input logic b1_we
);
    // R1
    bank0_write_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b0_we |-> (b0_en && !wr_bank));
    // R1
    bank1_write_owner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        b1_we |-> (b1_en && wr_bank));
    // R10
    single_writer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(b0_we && b1_we));
    // R10
    read_not_write_bank0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b0_en && !b0_we) |-> wr_bank);
    // R10
    read_not_write_bank1_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (b1_en && !b1_we) |-> !wr_bank);
    // R7
    reply_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
        disp_vld |-> $past(disp_req));
    // R9
    overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(overrun) |-> overrun);
endmodule

bind pingpong_frame_store fbuf_checker i_chk (
    .clk(clk), .rst_n(rst_n), .disp_req(disp_req), .disp_vld(disp_vld),
    .wr_bank(wr_bank), .overrun(overrun), .b0_en(b0_en), .b0_we(b0_we),
    .b1_en(b1_en), .b1_we(b1_we)
);

// File: tb/test_pingpong_frame_store.sv
module test_pingpong_frame_store;
    localparam int CLK_PERIOD = 10;
    localparam int FRAME_PIX  = 8;
    localparam int ADDR_W     = $clog2(FRAME_PIX / 2 + 1);
    localparam int DEPTH      = 1 << ADDR_W;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_grey = 1'b0;
    logic [15:0]       cam_pix = '0;
    logic              cam_valid = 1'b0, cam_eof = 1'b0, disp_req = 1'b0;
    logic [15:0]       disp_pix;
    logic              disp_vld, wr_bank, overrun;
    logic              b0_en, b0_we, b1_en, b1_we;
    logic [ADDR_W-1:0] b0_addr, b1_addr;
    logic [31:0]       b0_wdata, b1_wdata;
    logic [31:0]       b0_rdata = '0, b1_rdata = '0;
    logic [31:0]       mem0 [DEPTH];
    logic [31:0]       mem1 [DEPTH];

    int checks = 0, errors = 0, vld_seen = 0, fetches = 0;
    logic [15:0] exp_q [$];

    always #(CLK_PERIOD / 2) clk = ~clk;

    pingpong_frame_store #(.FRAME_PIX(FRAME_PIX)) i_pingpong_frame_store (
        .clk(clk), .rst_n(rst_n), .cfg_grey(cfg_grey), .cam_pix(cam_pix),
        .cam_valid(cam_valid), .cam_eof(cam_eof), .disp_req(disp_req),
        .disp_pix(disp_pix), .disp_vld(disp_vld), .wr_bank(wr_bank), .overrun(overrun),
        .b0_en(b0_en), .b0_we(b0_we), .b0_addr(b0_addr), .b0_wdata(b0_wdata), .b0_rdata(b0_rdata),
        .b1_en(b1_en), .b1_we(b1_we), .b1_addr(b1_addr), .b1_wdata(b1_wdata), .b1_rdata(b1_rdata)
    );

    // Bank models: synchronous single-port memories
    initial for (int i = 0; i < DEPTH; i++) begin mem0[i] = '0; mem1[i] = '0; end

    always @(posedge clk) begin
        if (b0_en) begin
            if (b0_we) mem0[b0_addr] <= b0_wdata;
            else       b0_rdata <= mem0[b0_addr];
        end
        if (b1_en) begin
            if (b1_we) mem1[b1_addr] <= b1_wdata;
            else       b1_rdata <= mem1[b1_addr];
        end
        if ((b0_en && !b0_we) || (b1_en && !b1_we)) fetches <= fetches + 1;
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // Scoreboard monitor
    always @(negedge clk) begin
        if (rst_n && disp_vld) begin
            vld_seen <= vld_seen + 1;
            checks++;
            if (exp_q.size() == 0) begin
                errors++;
                $display("FAIL R8 unexpected pixel actual %0h expected none", disp_pix);
            end else begin
                logic [15:0] e;
                e = exp_q.pop_front();
                if (disp_pix !== e) begin
                    errors++;
                    $display("FAIL R7 pixel actual %0h expected %0h", disp_pix, e);
                end
            end
        end
    end

    // Driver: writes a frame and pushes its expected read-back pixels
    task automatic write_frame(input logic [15:0] base, input logic grey, input int n,
                               input bit push, input bit flip_mid);
        @(negedge clk);
        cfg_grey = grey;
        repeat (2) @(negedge clk);
        for (int i = 0; i < n; i++) begin
            logic [15:0] p;
            p = base + 16'(i) * 16'h0101;
            cam_valid = 1'b1;
            cam_pix   = p;
            cam_eof   = (i == n - 1) && !flip_mid ? 1'b1 : ((i == n - 1) ? 1'b1 : 1'b0);
            if (push) exp_q.push_back(grey ? {8'h00, p[7:0]} : p);
            @(negedge clk);
            if (flip_mid && i == 0) cfg_grey = ~grey;
        end
        cam_valid = 1'b0;
        cam_eof   = 1'b0;
        cfg_grey  = grey;
        @(negedge clk);
    endtask

    task automatic drop_pixels(input logic [15:0] base, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cam_valid = 1'b1;
            cam_pix   = base + 16'(i);
        end
        @(negedge clk);
        cam_valid = 1'b0;
    endtask

    task automatic read_frame(input int n, input bit gap);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            disp_req = 1'b1;
            if (gap) begin
                @(negedge clk);
                disp_req = 1'b0;
            end
        end
        @(negedge clk);
        disp_req = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual running expected done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int f0, v0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state
        chk("R1 reset wr_bank", wr_bank, 0);
        chk("R9 reset overrun", overrun, 0);
        chk("R7 reset disp_vld", disp_vld, 0);
        chk("R8 reset bank idle", b0_en | b1_en, 0);

        // R8: nothing to read yet
        f0 = fetches; v0 = vld_seen;
        read_frame(3, 0);
        chk("R8 no reply without frame", vld_seen - v0, 0);
        chk("R8 no fetch without frame", fetches - f0, 0);

        // Frame 1, colour mode, bank 0, immediate exchange
        write_frame(16'h1100, 1'b0, FRAME_PIX, 1, 0);
        chk("R3 colour word 0", mem0[0], 32'h1201_1100);
        chk("R3 colour word 3", mem0[3], 32'h1807_1706);
        chk("R2 exchange on eof", wr_bank, 1);
        chk("R9 no overrun", overrun, 0);

        f0 = fetches;
        read_frame(FRAME_PIX, 0);
        chk("R7 colour fetch count", fetches - f0, FRAME_PIX / 2);

        // Frame 2, grey mode into bank 1, mode flipped mid-frame
        write_frame(16'h5010, 1'b1, FRAME_PIX, 1, 1);
        chk("R4 grey word 0", mem1[0], 32'h1312_1110);
        chk("R6 grey word 1 mode held", mem1[1], 32'h1716_1514);
        chk("R2 exchange back", wr_bank, 0);

        f0 = fetches;
        read_frame(FRAME_PIX, 1);
        chk("R7 grey fetch count", fetches - f0, FRAME_PIX / 4);

        // Frame 3 into bank 0, then frame 4 while frame 3 unread
        write_frame(16'h2200, 1'b0, FRAME_PIX, 1, 0);
        chk("R2 frame 3 restarts at 0", mem0[0], 32'h2301_2200);
        chk("R1 bank after frame 3", wr_bank, 1);
        write_frame(16'h3300, 1'b0, FRAME_PIX, 1, 0);
        chk("R9 overrun set", overrun, 1);
        chk("R9 exchange held", wr_bank, 1);
        drop_pixels(16'h4400, 4);
        chk("R9 pixels dropped", mem1[0], 32'h3401_3300);
        chk("R9 still held", wr_bank, 1);

        read_frame(FRAME_PIX, 0);
        chk("R9 late exchange", wr_bank, 0);
        chk("R9 overrun sticky", overrun, 1);
        read_frame(FRAME_PIX, 0);

        // Early end of frame in grey mode
        write_frame(16'h6000, 1'b1, 6, 0, 0);
        chk("R5 full word", mem0[0], 32'h0302_0100);
        chk("R5 partial word zero fill", mem0[1], 32'h0000_0504);
        chk("R7 all pixels delivered", exp_q.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule